// File: doc/BRIEF.md
# Privilege Mode Exception Controller

This block keeps the processor's privilege level (user or kernel) and its global interrupt enable. It decides when control passes to the operating system and when it returns. A system call, a synchronous fault reported by the pipeline, or an external interrupt accepted at an instruction boundary all lead to the same result. The block saves a return address and a cause code, switches to kernel mode, masks interrupts and steers fetch to a single handler entry point. A return-from-exception strobe reverses this in one step. It drops to user mode, re-enables interrupts and steers fetch back to the saved address.

The saved address and the cause code are exposed to kernel software as two privileged registers. They are reached through a select/read/write port. Any attempt from user mode to touch them, or to execute the return instruction, is turned into an illegal-instruction trap rather than carried out. The pipeline sees a one-cycle redirect pulse with a target address. It also sees the current mode, the interrupt enable and a flag marking redirects caused by an illegal access.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the block is in kernel mode with interrupts disabled, the saved return address reads 0, the cause code reads 0 and no redirect is issued.
- R2: A system call strobe saves `pc_i` as return address and cause code 8, enters kernel mode, clears the interrupt enable and, one cycle later, pulses `redirect_o` with target `HANDLER` (default 0x80000180).
- R3: A fault strobe saves `pc_i` and the supplied code (1 = page fault, 2 = protection fault) and redirects to `HANDLER` exactly like R2.
- R4: An external interrupt (any bit of `irq_i` high) is taken only in a cycle with `retire_i` high and the interrupt enable set. It saves `pc_i + INSTR_BYTES` and cause code 0, and redirects to `HANDLER`.
- R5: While the interrupt enable is clear, a raised interrupt line causes no redirect; it remains pending and is taken at the first boundary after the enable is set.
- R6: A return strobe in kernel mode selects user mode, sets the interrupt enable and, one cycle later, redirects to the saved return address.
- R7: In user mode a register read, a register write or a return strobe raises an illegal-instruction trap: cause code 10, return address `pc_i`, `illegal_o` high with the redirect. The read returns 0 and the write does not land.
- R8: A synchronous event beats an interrupt in the same cycle, and the interrupt stays pending. Among synchronous events, illegal access beats a fault, and a fault beats a system call.
- R9: In kernel mode, select 0 addresses the return address and select 1 the cause register. A write to the return address clears its low log2(INSTR_BYTES) bits. A cause read returns the code in bits [4:0] and the live `irq_i` lines in bits [8+NIRQ-1:8].
- R10: A register write in the same cycle as a trap is dropped; the trap's saved values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | Address of the instruction in the current cycle |
| retire_i | input | 1 | Current instruction completes this cycle (interrupt boundary) |
| syscall_i | input | 1 | System call strobe |
| fault_i | input | 1 | Synchronous fault strobe |
| fault_code_i | input | 5 | Cause code of the fault |
| irq_i | input | NIRQ | External interrupt lines, level sensitive |
| eret_i | input | 1 | Return-from-exception strobe |
| sreg_rd_i | input | 1 | Privileged register read |
| sreg_wr_i | input | 1 | Privileged register write |
| sreg_sel_i | input | 1 | 0 = return address, 1 = cause |
| sreg_wdata_i | input | XLEN | Write data |
| sreg_rdata_o | output | XLEN | Read data (0 unless a kernel-mode read) |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | XLEN | Redirect target |
| kernel_mode_o | output | 1 | 1 = kernel mode |
| irq_en_o | output | 1 | Global interrupt enable |
| illegal_o | output | 1 | Redirect was caused by an illegal privileged access |

## Verification
The hardest situation to reach is an interrupt that has to stay pending across several events. It is held through a masked stretch of kernel mode with instruction boundaries passing. It also loses a same-cycle race to a fault and then must still be taken afterwards. The stimulus holds one interrupt line high throughout that sequence, keeps retiring instructions while the enable is clear, and returns to user mode. It then fires a protection fault on a boundary cycle, returns again, and expects the interrupt on the next boundary with the incremented return address. Each illegal-access case is also driven with write data that differs from the trapping address. The saved value then shows whether the blocked write leaked through.

// File: rtl/pt_pkg.sv
package pt_pkg;

   typedef enum logic [4:0] {
      CC_IRQ     = 5'd0,
      CC_PAGE    = 5'd1,
      CC_PROT    = 5'd2,
      CC_SYSCALL = 5'd8,
      CC_ILLEGAL = 5'd10
   } cause_e;

   localparam int CODE_W = 5;

   typedef enum logic {
      SR_EPC   = 1'b0,
      SR_CAUSE = 1'b1
   } sreg_e;

   typedef struct packed {
      logic       take;
      logic       is_sync;
      logic       is_irq;
      logic       illegal;
      logic [4:0] code;
   } trap_t;

endpackage

// File: rtl/pt_trap_select.sv
module pt_trap_select
   import pt_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int NIRQ        = 4,
   parameter int INSTR_BYTES = 4
) (
   input  logic               kernel_i,
   input  logic               ie_i,
   input  logic               retire_i,
   input  logic               syscall_i,
   input  logic               fault_i,
   input  logic [CODE_W-1:0]  fault_code_i,
   input  logic [NIRQ-1:0]    irq_i,
   input  logic               eret_i,
   input  logic               sreg_rd_i,
   input  logic               sreg_wr_i,
   input  logic [XLEN-1:0]    pc_i,
   output trap_t              trap_o,
   output logic [XLEN-1:0]    trap_epc_o,
   output logic               eret_ok_o,
   output logic               sreg_ok_o
);

   localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

   logic priv_req;
   logic illegal;
   logic sync_req;
   logic irq_any;
   logic irq_take;

   assign priv_req = sreg_rd_i | sreg_wr_i | eret_i;
   assign illegal  = ~kernel_i & priv_req;
   assign sync_req = illegal | fault_i | syscall_i;
   assign irq_any  = |irq_i;
   assign irq_take = irq_any & ie_i & retire_i & ~sync_req;

   always_comb begin
      trap_o         = '0;
      trap_o.take    = sync_req | irq_take;
      trap_o.is_sync = sync_req;
      trap_o.is_irq  = irq_take;
      trap_o.illegal = illegal;
      if (illegal)        trap_o.code = CC_ILLEGAL;
      else if (fault_i)   trap_o.code = fault_code_i;
      else if (syscall_i) trap_o.code = CC_SYSCALL;
      else                trap_o.code = CC_IRQ;
   end

   assign trap_epc_o = irq_take ? (pc_i + STEP) : pc_i;
   assign eret_ok_o  = kernel_i & eret_i & ~sync_req;
   assign sreg_ok_o  = kernel_i & ~sync_req;

endmodule

// File: rtl/pt_mode_reg.sv
module pt_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic trap_i,
   input  logic eret_i,
   output logic kernel_o,
   output logic ie_o
);

   logic kernel_q;
   logic ie_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kernel_q <= 1'b1;
         ie_q     <= 1'b0;
      end else if (trap_i) begin
         kernel_q <= 1'b1;
         ie_q     <= 1'b0;
      end else if (eret_i) begin
         kernel_q <= 1'b0;
         ie_q     <= 1'b1;
      end
   end

   assign kernel_o = kernel_q;
   assign ie_o     = ie_q;

   p_trap_enters_kernel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> (kernel_q && !ie_q))
      else $error("trap did not enter kernel with interrupts masked");

   p_eret_restores_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_i && !trap_i) |=> (!kernel_q && ie_q))
      else $error("return did not restore user mode and enable");

endmodule

// File: rtl/pt_sysregs.sv
module pt_sysregs
   import pt_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int NIRQ        = 4,
   parameter int PEND_LSB    = 8,
   parameter int INSTR_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [XLEN-1:0]   cap_epc_i,
   input  logic [CODE_W-1:0] cap_code_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic              sel_i,
   input  logic [XLEN-1:0]   wdata_i,
   input  logic [NIRQ-1:0]   irq_i,
   output logic [XLEN-1:0]   epc_o,
   output logic [XLEN-1:0]   rdata_o
);

   localparam int ALIGN = (INSTR_BYTES > 1) ? $clog2(INSTR_BYTES) : 0;

   logic [XLEN-1:0]   epc_q;
   logic [CODE_W-1:0] code_q;
   logic [XLEN-1:0]   wdata_al;
   logic [XLEN-1:0]   cause_view;

   generate
      if (ALIGN > 0) begin : g_align
         assign wdata_al = {wdata_i[XLEN-1:ALIGN], {ALIGN{1'b0}}};
      end else begin : g_noalign
         assign wdata_al = wdata_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q  <= '0;
         code_q <= '0;
      end else if (capture_i) begin
         epc_q  <= cap_epc_i;
         code_q <= cap_code_i;
      end else if (wr_en_i) begin
         if (sel_i == SR_EPC) epc_q  <= wdata_al;
         else                 code_q <= wdata_i[CODE_W-1:0];
      end
   end

   always_comb begin
      cause_view                     = '0;
      cause_view[CODE_W-1:0]         = code_q;
      cause_view[PEND_LSB +: NIRQ]   = irq_i;
   end

   assign epc_o   = epc_q;
   assign rdata_o = !rd_en_i ? '0 : ((sel_i == SR_CAUSE) ? cause_view : epc_q);

   p_capture_epc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> (epc_q == $past(cap_epc_i) && code_q == $past(cap_code_i)))
      else $error("trap values not captured");

   p_write_dropped_on_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_i && wr_en_i) |=> (epc_q == $past(cap_epc_i)))
      else $error("write overrode trap capture");

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
   import pt_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              NIRQ        = 4,
   parameter int              INSTR_BYTES = 4,
   parameter int              PEND_LSB    = 8,
   parameter logic [XLEN-1:0] HANDLER     = 32'h8000_0180
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XLEN-1:0]   pc_i,
   input  logic              retire_i,
   input  logic              syscall_i,
   input  logic              fault_i,
   input  logic [4:0]        fault_code_i,
   input  logic [NIRQ-1:0]   irq_i,
   input  logic              eret_i,
   input  logic              sreg_rd_i,
   input  logic              sreg_wr_i,
   input  logic              sreg_sel_i,
   input  logic [XLEN-1:0]   sreg_wdata_i,
   output logic [XLEN-1:0]   sreg_rdata_o,
   output logic              redirect_o,
   output logic [XLEN-1:0]   redirect_pc_o,
   output logic              kernel_mode_o,
   output logic              irq_en_o,
   output logic              illegal_o
);

   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("XLEN must be at least 16");
      end
      if (NIRQ < 1 || PEND_LSB + NIRQ > XLEN) begin : g_bad_nirq
         $error("NIRQ does not fit in the cause register");
      end
      if (PEND_LSB < CODE_W) begin : g_bad_pend
         $error("pending field overlaps the cause code");
      end
      if (INSTR_BYTES < 1 || (INSTR_BYTES & (INSTR_BYTES - 1)) != 0) begin : g_bad_step
         $error("INSTR_BYTES must be a power of two");
      end
   endgenerate

   trap_t           trap;
   logic [XLEN-1:0] trap_epc;
   logic            eret_ok;
   logic            sreg_ok;
   logic            kernel;
   logic            ie;
   logic [XLEN-1:0] epc;
   logic [XLEN-1:0] rdata;

   logic            redirect_q;
   logic [XLEN-1:0] target_q;
   logic            illegal_q;

   pt_trap_select #(
      .XLEN(XLEN), .NIRQ(NIRQ), .INSTR_BYTES(INSTR_BYTES)
   ) u_select (
      .kernel_i     (kernel),
      .ie_i         (ie),
      .retire_i     (retire_i),
      .syscall_i    (syscall_i),
      .fault_i      (fault_i),
      .fault_code_i (fault_code_i),
      .irq_i        (irq_i),
      .eret_i       (eret_i),
      .sreg_rd_i    (sreg_rd_i),
      .sreg_wr_i    (sreg_wr_i),
      .pc_i         (pc_i),
      .trap_o       (trap),
      .trap_epc_o   (trap_epc),
      .eret_ok_o    (eret_ok),
      .sreg_ok_o    (sreg_ok)
   );

   pt_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .trap_i   (trap.take),
      .eret_i   (eret_ok),
      .kernel_o (kernel),
      .ie_o     (ie)
   );

   pt_sysregs #(
      .XLEN(XLEN), .NIRQ(NIRQ), .PEND_LSB(PEND_LSB), .INSTR_BYTES(INSTR_BYTES)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_i  (trap.take),
      .cap_epc_i  (trap_epc),
      .cap_code_i (trap.code),
      .wr_en_i    (sreg_wr_i & sreg_ok),
      .rd_en_i    (sreg_rd_i & kernel),
      .sel_i      (sreg_sel_i),
      .wdata_i    (sreg_wdata_i),
      .irq_i      (irq_i),
      .epc_o      (epc),
      .rdata_o    (rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_q <= 1'b0;
         target_q   <= '0;
         illegal_q  <= 1'b0;
      end else begin
         redirect_q <= trap.take | eret_ok;
         target_q   <= trap.take ? HANDLER : epc;
         illegal_q  <= trap.take & trap.illegal;
      end
   end

   assign sreg_rdata_o  = rdata;
   assign redirect_o    = redirect_q;
   assign redirect_pc_o = target_q;
   assign kernel_mode_o = kernel;
   assign irq_en_o      = ie;
   assign illegal_o     = illegal_q;

   p_trap_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trap.take |=> (redirect_o && redirect_pc_o == HANDLER))
      else $error("trap redirect target wrong");

   p_eret_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eret_ok |=> (redirect_o && redirect_pc_o == $past(epc)))
      else $error("return redirect target wrong");

   p_masked_irq_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie && !trap.is_sync && !eret_ok) |=> !redirect_o)
      else $error("redirect while interrupts masked");

   p_user_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!kernel_mode_o && sreg_rd_i) |-> (sreg_rdata_o == '0))
      else $error("user mode read leaked data");

   p_illegal_in_kernel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (kernel_mode_o && !irq_en_o))
      else $error("illegal flag without kernel entry");

endmodule

// File: tb/priv_trap_ctrl_bench.sv
module priv_trap_ctrl_bench;

   localparam int          XLEN = 32;
   localparam int          NIRQ = 4;
   localparam logic [31:0] H    = 32'h8000_0180;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [XLEN-1:0] pc = '0;
   logic            retire = 1'b0;
   logic            syscall = 1'b0;
   logic            fault = 1'b0;
   logic [4:0]      fcode = '0;
   logic [NIRQ-1:0] irq = '0;
   logic            eret = 1'b0;
   logic            rd = 1'b0;
   logic            wr = 1'b0;
   logic            sel = 1'b0;
   logic [XLEN-1:0] wdata = '0;
   logic [XLEN-1:0] rdata;
   logic            redirect;
   logic [XLEN-1:0] redirect_pc;
   logic            kernel;
   logic            ie;
   logic            illegal;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [31:0] pc;
      logic        ill;
   } exp_t;
   exp_t expq[$];

   always #2 clk = ~clk;

   priv_trap_ctrl u_priv_trap_ctrl (
      .clk(clk), .rst_n(rst_n), .pc_i(pc), .retire_i(retire),
      .syscall_i(syscall), .fault_i(fault), .fault_code_i(fcode),
      .irq_i(irq), .eret_i(eret), .sreg_rd_i(rd), .sreg_wr_i(wr),
      .sreg_sel_i(sel), .sreg_wdata_i(wdata), .sreg_rdata_o(rdata),
      .redirect_o(redirect), .redirect_pc_o(redirect_pc),
      .kernel_mode_o(kernel), .irq_en_o(ie), .illegal_o(illegal)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // Monitor: every redirect must match the next expected item.
   always @(negedge clk) begin
      if (rst_n && redirect) begin
         checks++;
         if (expq.size() == 0) begin
            errors++;
            $display("FAIL R5 unexpected redirect: actual 0x%08h expected none", redirect_pc);
         end else begin
            exp_t e;
            e = expq.pop_front();
            if (redirect_pc !== e.pc || illegal !== e.ill) begin
               errors++;
               $display("FAIL R2/R6/R7 redirect: actual 0x%08h/%0b expected 0x%08h/%0b",
                        redirect_pc, illegal, e.pc, e.ill);
            end
         end
      end
   end

   task automatic expect_redirect(input logic [31:0] t, input logic ill);
      exp_t e;
      e.pc  = t;
      e.ill = ill;
      expq.push_back(e);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      retire = 0; syscall = 0; fault = 0; eret = 0; rd = 0; wr = 0;
   endtask

   task automatic read_reg(input logic s, input logic [31:0] exp, input string req);
      rd = 1; sel = s;
      #1;
      chk(req, rdata, exp);
      tick();
   endtask

   task automatic write_reg(input logic s, input logic [31:0] v);
      wr = 1; sel = s; wdata = v;
      tick();
   endtask

   task automatic do_eret(input logic [31:0] target);
      eret = 1;
      expect_redirect(target, 1'b0);
      tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 kernel", {31'd0, kernel}, 32'd1);
      chk("R1 ie", {31'd0, ie}, 32'd0);
      chk("R1 redirect", {31'd0, redirect}, 32'd0);
      read_reg(0, 32'h0, "R1 epc");
      read_reg(1, 32'h0, "R1 cause");

      write_reg(0, 32'h0000_1003);
      read_reg(0, 32'h0000_1000, "R9 epc align");
      write_reg(1, 32'd5);
      read_reg(1, 32'd5, "R9 cause write");

      do_eret(32'h1000);
      chk("R6 user", {31'd0, kernel}, 32'd0);
      chk("R6 ie", {31'd0, ie}, 32'd1);

      pc = 32'h1000; syscall = 1; expect_redirect(H, 0); tick();
      chk("R2 kernel", {31'd0, kernel}, 32'd1);
      chk("R2 ie", {31'd0, ie}, 32'd0);
      read_reg(0, 32'h1000, "R2 epc");
      read_reg(1, 32'd8, "R2 cause");
      do_eret(32'h1000);

      pc = 32'h2000; fault = 1; fcode = 5'd1; expect_redirect(H, 0); tick();
      read_reg(1, 32'd1, "R3 page cause");
      read_reg(0, 32'h2000, "R3 epc");
      do_eret(32'h2000);
      pc = 32'h2004; fault = 1; fcode = 5'd2; expect_redirect(H, 0); tick();
      read_reg(1, 32'd2, "R3 prot cause");
      do_eret(32'h2004);

      pc = 32'h3000; rd = 1; sel = 0;
      #1;
      chk("R7 user read zero", rdata, 32'h0);
      expect_redirect(H, 1); tick();
      read_reg(1, 32'd10, "R7 read cause");
      read_reg(0, 32'h3000, "R7 read epc");
      do_eret(32'h3000);

      pc = 32'h3010; wr = 1; sel = 0; wdata = 32'h0000_ABC0;
      expect_redirect(H, 1); tick();
      read_reg(0, 32'h3010, "R7 write blocked");
      read_reg(1, 32'd10, "R7 write cause");
      do_eret(32'h3010);

      pc = 32'h3020; eret = 1; expect_redirect(H, 1); tick();
      read_reg(1, 32'd10, "R7 eret cause");
      read_reg(0, 32'h3020, "R7 eret epc");
      do_eret(32'h3020);

      pc = 32'h3030; syscall = 1; rd = 1; sel = 1;
      expect_redirect(H, 1); tick();
      read_reg(1, 32'd10, "R8 illegal over syscall");
      do_eret(32'h3030);

      irq = 4'b0001;
      tick(); tick();
      chk("R4 no boundary", {31'd0, kernel}, 32'd0);
      pc = 32'h4000; retire = 1; expect_redirect(H, 0); tick();
      read_reg(0, 32'h4004, "R4 epc");
      read_reg(1, 32'h100, "R4 R9 cause pending");
      for (int i = 0; i < 3; i++) begin
         retire = 1; tick();
      end
      chk("R5 held", {31'd0, kernel}, 32'd1);
      do_eret(32'h4004);
      pc = 32'h4004; retire = 1; expect_redirect(H, 0); tick();
      read_reg(0, 32'h4008, "R5 taken after enable");
      do_eret(32'h4008);

      irq = 4'b0100;
      pc = 32'h5000; retire = 1; fault = 1; fcode = 5'd2;
      expect_redirect(H, 0); tick();
      read_reg(1, 32'h402, "R8 fault over irq");
      do_eret(32'h5000);
      pc = 32'h5000; retire = 1; expect_redirect(H, 0); tick();
      read_reg(1, 32'h400, "R8 irq still pending");
      read_reg(0, 32'h5004, "R8 irq epc");

      irq = '0;
      pc = 32'h6000; fault = 1; fcode = 5'd1; wr = 1; sel = 0; wdata = 32'h5550;
      expect_redirect(H, 0); tick();
      read_reg(0, 32'h6000, "R10 write dropped");
      read_reg(1, 32'd1, "R10 cause");

      tick(); tick();
      chk("R2 queue drained", expq.size(), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule